// File: doc/BRIEF.md
# Masked Vector Compress/Expand Unit

This unit packs or unpacks the lanes of a 512-bit vector under control of a per-lane mask. In compress mode, lanes whose mask bit is set are gathered and laid down side by side starting at lane 0. In expand mode, elements are taken in order from the bottom of the source and dropped into the lanes whose mask bit is set. Elements are either 32 bits wide (16 lanes) or 64 bits wide (8 lanes).

A 3-bit selector decides whether the operation is masked. Selector 0 means unmasked: every lane counts as selected, whatever the supplied mask is. Any other selector value applies the supplied mask word. A fill flag decides what happens to result lanes the operation does not write. They are either cleared or given the corresponding lane of a prior destination vector. The result is registered once and is qualified by a valid output that follows the input strobe by one clock.

Top module: `vcx_unit`

## Requirements
- R1: In compress mode (`op_expand`=0), the selected source lanes appear in result lanes 0, 1, 2, … in ascending source-lane order, with no gaps.
- R2: In compress mode, result lanes at or above the number of selected lanes are 0 when `zero_fill`=1 and equal the same lane of `dst_vec` when `zero_fill`=0.
- R3: In expand mode (`op_expand`=1), the k-th selected result lane (counting from lane 0 upward) receives source lane k.
- R4: In expand mode, unselected result lanes are 0 when `zero_fill`=1 and equal the same lane of `dst_vec` when `zero_fill`=0.
- R5: With `elem64`=0, elements are 32 bits: lane i is `[32*i+31:32*i]`, and all 16 bits of `mask_val` apply, bit i to lane i.
- R6: With `elem64`=1, elements are 64 bits: lane i is `[64*i+63:64*i]`, only `mask_val[7:0]` applies, and `mask_val[15:8]` has no effect on the result.
- R7: When `mask_sel`=0, every lane is selected and `mask_val` has no effect; in either mode the result then equals `src_vec`. When `mask_sel` is 1 to 7, `mask_val` is applied.
- R8: `out_valid` is 1 exactly one clock after a cycle with `in_valid`=1 and 0 otherwise. A synchronous active-high `rst` clears `out_valid` and `out_vec` to 0.
- R9: `out_vec` changes only in the clock after an `in_valid` cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; inputs are captured on this cycle |
| op_expand | input | 1 | 0 = compress, 1 = expand |
| elem64 | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| zero_fill | input | 1 | 1 = clear unwritten lanes, 0 = keep `dst_vec` lanes |
| mask_sel | input | 3 | 0 = unmasked, 1..7 = apply `mask_val` |
| mask_val | input | 16 | Per-lane mask, bit i for lane i |
| src_vec | input | 512 | Source vector |
| dst_vec | input | 512 | Prior destination vector used for merging |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_vec | output | 512 | Registered result vector |

## Verification
The bench compares the result against a lane-by-lane loop model. It uses sparse, dense, all-clear and all-set masks in both modes and at both element sizes. A design that miscounted the prefix of set bits would shift compressed lanes by one or repeat an element in expand mode. A design that ignored the fill flag would leave stale merge data where zeros belong, or zeros where the prior destination should show. Paired runs with only `mask_val[15:8]` changed at 64-bit size catch a design that reads mask bits beyond lane 7. Runs with selector 0 and a cleared mask catch a design that still honours `mask_val` when masking is off.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
    localparam int VEC_W  = 512;
    localparam int GRAN_W = 32;
    localparam int N_GRAN = VEC_W / GRAN_W;
    localparam int N_WIDE = N_GRAN / 2;
    localparam int CNT_W  = $clog2(N_GRAN + 1);
    localparam int IDX_W  = $clog2(N_GRAN);
    localparam int SEL_W  = 3;

    typedef logic [GRAN_W-1:0]            gran_t;
    typedef gran_t [N_GRAN-1:0]           gvec_t;
    typedef logic [N_GRAN-1:0]            gmask_t;
    typedef logic [CNT_W-1:0]             cnt_t;
    typedef cnt_t [N_GRAN-1:0]            cntvec_t;

    typedef enum logic { OP_COMPRESS = 1'b0, OP_EXPAND = 1'b1 } op_mode_e;
    typedef enum logic { FILL_MERGE = 1'b0, FILL_ZERO = 1'b1 } fill_mode_e;

    // Mask selector value 0 stands for "no masking".
    function automatic gmask_t select_mask(input logic [SEL_W-1:0] sel,
                                           input gmask_t supplied);
        return (sel == '0) ? '1 : supplied;
    endfunction
endpackage

// File: rtl/vcx_mask_gen.sv
module vcx_mask_gen
    import vcx_pkg::*;
(
    input  logic [SEL_W-1:0] mask_sel,
    input  gmask_t           mask_val,
    input  logic             elem64,
    output gmask_t           gmask
);
    gmask_t raw;
    gmask_t wide;

    assign raw = select_mask(mask_sel, mask_val);

    // 64-bit lanes span two granules; each uses one low mask bit twice.
    generate
        for (genvar k = 0; k < N_WIDE; k++) begin : g_pair
            assign wide[2*k]   = raw[k];
            assign wide[2*k+1] = raw[k];
        end
    endgenerate

    assign gmask = elem64 ? wide : raw;
endmodule

// File: rtl/vcx_prefix.sv
module vcx_prefix
    import vcx_pkg::*;
(
    input  gmask_t  gmask,
    output cntvec_t pre,
    output cnt_t    total
);
    // pre[i] = number of set mask bits below granule i
    generate
        for (genvar i = 0; i < N_GRAN; i++) begin : g_pre
            if (i == 0) begin : g_first
                assign pre[i] = '0;
            end else begin : g_rest
                assign pre[i] = pre[i-1] + cnt_t'(gmask[i-1]);
            end
        end
    endgenerate

    assign total = pre[N_GRAN-1] + cnt_t'(gmask[N_GRAN-1]);
endmodule

// File: rtl/vcx_route.sv
module vcx_route
    import vcx_pkg::*;
(
    input  op_mode_e   mode,
    input  fill_mode_e fill,
    input  gmask_t     gmask,
    input  cntvec_t    pre,
    input  cnt_t       total,
    input  gvec_t      src,
    input  gvec_t      dst,
    output gvec_t      res
);
    always_comb begin
        for (int j = 0; j < N_GRAN; j++) begin
            gran_t pick;
            logic  wr;
            pick = '0;
            if (mode == OP_COMPRESS) begin
                for (int i = 0; i < N_GRAN; i++) begin
                    if (gmask[i] && (pre[i] == cnt_t'(j)))
                        pick = pick | src[i];
                end
                wr = (cnt_t'(j) < total);
            end else begin
                pick = src[pre[j][IDX_W-1:0]];
                wr   = gmask[j];
            end
            if (wr)
                res[j] = pick;
            else if (fill == FILL_ZERO)
                res[j] = '0;
            else
                res[j] = dst[j];
        end
    end
endmodule

// File: rtl/vcx_unit.sv
module vcx_unit
    import vcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_expand,
    input  logic              elem64,
    input  logic              zero_fill,
    input  logic [2:0]        mask_sel,
    input  logic [15:0]       mask_val,
    input  logic [511:0]      src_vec,
    input  logic [511:0]      dst_vec,
    output logic              out_valid,
    output logic [511:0]      out_vec
);
    gmask_t  gmask;
    cntvec_t pre;
    cnt_t    total;
    gvec_t   src_g, dst_g, res_g;

    assign src_g = src_vec;
    assign dst_g = dst_vec;

    vcx_mask_gen u_mask (
        .mask_sel (mask_sel),
        .mask_val (mask_val),
        .elem64   (elem64),
        .gmask    (gmask)
    );

    vcx_prefix u_pre (
        .gmask (gmask),
        .pre   (pre),
        .total (total)
    );

    vcx_route u_route (
        .mode  (op_mode_e'(op_expand)),
        .fill  (fill_mode_e'(zero_fill)),
        .gmask (gmask),
        .pre   (pre),
        .total (total),
        .src   (src_g),
        .dst   (dst_g),
        .res   (res_g)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_vec <= res_g;
        end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec));

    // R7
    unmasked_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_sel == 3'd0) |=> (out_vec == $past(src_vec)));

    // R2 R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && zero_fill && mask_sel != 3'd0 && mask_val == 16'h0)
        |=> (out_vec == '0));

    // R2 R4
    empty_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !zero_fill && mask_sel != 3'd0 && mask_val == 16'h0)
        |=> (out_vec == $past(dst_vec)));
endmodule

// File: tb/sim_vcx_unit.sv
module sim_vcx_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         op_expand = 1'b0;
    logic         elem64 = 1'b0;
    logic         zero_fill = 1'b0;
    logic [2:0]   mask_sel = 3'd0;
    logic [15:0]  mask_val = 16'h0;
    logic [511:0] src_vec = '0;
    logic [511:0] dst_vec = '0;
    logic         out_valid;
    logic [511:0] out_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vcx_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_expand(op_expand),
        .elem64(elem64), .zero_fill(zero_fill), .mask_sel(mask_sel),
        .mask_val(mask_val), .src_vec(src_vec), .dst_vec(dst_vec),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    // {expand, elem64, zero_fill, sel[2:0], mask[15:0]}
    localparam logic [21:0] TBL [12] = '{
        {1'b0, 1'b0, 1'b1, 3'd1, 16'hA5A5},
        {1'b0, 1'b0, 1'b0, 3'd2, 16'h8001},
        {1'b1, 1'b0, 1'b1, 3'd3, 16'h00F0},
        {1'b1, 1'b0, 1'b0, 3'd7, 16'hF00F},
        {1'b0, 1'b1, 1'b1, 3'd1, 16'h00C3},
        {1'b0, 1'b1, 1'b0, 3'd4, 16'hFF5A},
        {1'b1, 1'b1, 1'b1, 3'd5, 16'h0081},
        {1'b1, 1'b1, 1'b0, 3'd6, 16'hAA66},
        {1'b0, 1'b0, 1'b1, 3'd0, 16'h0000},
        {1'b1, 1'b1, 1'b0, 3'd0, 16'h1234},
        {1'b0, 1'b0, 1'b0, 3'd1, 16'h0000},
        {1'b1, 1'b0, 1'b1, 3'd1, 16'hFFFF}
    };

    function automatic logic [511:0] mkvec(input int seed);
        logic [511:0] v;
        for (int k = 0; k < 16; k++)
            v[k*32 +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(k) * 32'h01010101) ^ 32'(k << 24);
        return v;
    endfunction

    function automatic logic [511:0] ref_model(input bit ex, input bit e64, input bit zf,
                                               input bit [2:0] sel, input bit [15:0] m,
                                               input logic [511:0] s, input logic [511:0] d);
        logic [511:0] r;
        bit [15:0] em;
        int n, g, k;
        r  = '0;
        em = (sel == 3'd0) ? 16'hFFFF : m;
        n  = e64 ? 8 : 16;
        g  = e64 ? 2 : 1;
        k  = 0;
        if (!ex) begin
            for (int i = 0; i < n; i++)
                if (em[i]) begin
                    for (int t = 0; t < g; t++)
                        r[(k*g+t)*32 +: 32] = s[(i*g+t)*32 +: 32];
                    k++;
                end
            for (int j = k; j < n; j++)
                for (int t = 0; t < g; t++)
                    r[(j*g+t)*32 +: 32] = zf ? 32'h0 : d[(j*g+t)*32 +: 32];
        end else begin
            for (int i = 0; i < n; i++) begin
                for (int t = 0; t < g; t++)
                    r[(i*g+t)*32 +: 32] = em[i] ? s[(k*g+t)*32 +: 32]
                                                : (zf ? 32'h0 : d[(i*g+t)*32 +: 32]);
                if (em[i]) k++;
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input bit ex, input bit e64, input bit [2:0] sel);
        string s;
        s = ex ? "R3 R4" : "R1 R2";
        s = {s, e64 ? " R6" : " R5"};
        if (sel == 3'd0) s = {s, " R7"};
        return s;
    endfunction

    task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge; sample the registered result at the next one.
    task automatic run_op(input bit ex, input bit e64, input bit zf, input bit [2:0] sel,
                          input bit [15:0] m, input logic [511:0] s, input logic [511:0] d,
                          output logic [511:0] got, output logic vld);
        @(negedge clk);
        in_valid = 1'b1; op_expand = ex; elem64 = e64; zero_fill = zf;
        mask_sel = sel; mask_val = m; src_vec = s; dst_vec = d;
        @(negedge clk);
        in_valid = 1'b0;
        got = out_vec;
        vld = out_valid;
    endtask

    task automatic run_and_check(input bit ex, input bit e64, input bit zf, input bit [2:0] sel,
                                 input bit [15:0] m, input int seed);
        logic [511:0] s, d, got;
        logic vld;
        s = mkvec(seed);
        d = mkvec(seed + 7777);
        run_op(ex, e64, zf, sel, m, s, d, got, vld);
        check_vec(tag_of(ex, e64, sel), got, ref_model(ex, e64, zf, sel, m, s, d));
        check_bit("R8 valid after strobe", vld, 1'b1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [511:0] a, b, s, d, held;
        logic vld;

        repeat (3) @(negedge clk);
        // R8: reset state
        check_bit("R8 reset valid", out_valid, 1'b0);
        check_vec("R8 reset result", out_vec, '0);
        @(negedge clk);
        rst = 1'b0;

        // Table-driven vectors
        for (int e = 0; e < 12; e++)
            run_and_check(TBL[e][21], TBL[e][20], TBL[e][19], TBL[e][18:16], TBL[e][15:0], e + 1);

        // R8: valid drops one cycle after the strobe; R9: result holds
        held = out_vec;
        @(negedge clk);
        check_bit("R8 valid idle", out_valid, 1'b0);
        src_vec = ~src_vec; dst_vec = ~dst_vec; mask_val = ~mask_val;
        @(negedge clk);
        check_vec("R9 hold without strobe", out_vec, held);

        // R6: upper mask bits ignored with 64-bit elements
        s = mkvec(101); d = mkvec(202);
        run_op(1'b0, 1'b1, 1'b0, 3'd2, 16'h0033, s, d, a, vld);
        run_op(1'b0, 1'b1, 1'b0, 3'd2, 16'hFF33, s, d, b, vld);
        check_vec("R6 compress upper mask ignored", b, a);
        run_op(1'b1, 1'b1, 1'b1, 3'd2, 16'h0096, s, d, a, vld);
        run_op(1'b1, 1'b1, 1'b1, 3'd2, 16'h6996, s, d, b, vld);
        check_vec("R6 expand upper mask ignored", b, a);

        // R7: selector 0 ignores a cleared mask
        run_op(1'b0, 1'b0, 1'b1, 3'd0, 16'h0000, s, d, a, vld);
        check_vec("R7 unmasked compress", a, s);
        run_op(1'b1, 1'b1, 1'b1, 3'd0, 16'h0000, s, d, a, vld);
        check_vec("R7 unmasked expand", a, s);

        // R2 R4: empty mask with merge and zero fill
        run_op(1'b1, 1'b0, 1'b0, 3'd3, 16'h0000, s, d, a, vld);
        check_vec("R4 expand empty merge", a, d);
        run_op(1'b0, 1'b1, 1'b1, 3'd3, 16'h0000, s, d, a, vld);
        check_vec("R2 compress empty zero", a, '0);

        // Random sweep with forced all-clear and all-set masks
        for (int it = 0; it < 300; it++) begin
            bit [15:0] m;
            m = 16'($urandom);
            if (it % 10 == 3) m = 16'h0000;
            if (it % 10 == 7) m = 16'hFFFF;
            run_and_check(1'($urandom), 1'($urandom), 1'($urandom),
                          (it % 9 == 0) ? 3'd0 : 3'(1 + ($urandom % 7)), m, 1000 + it);
        end

        // R8: synchronous reset clears valid and result
        @(negedge clk);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check_bit("R8 reset clears valid", out_valid, 1'b0);
        check_vec("R8 reset clears result", out_vec, '0);
        in_valid = 1'b0;
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule